// File: doc/BRIEF.md
# Registered Integer ALU with Branch Condition Flag

This block is the execute-stage arithmetic unit of a simple 32-bit load/store datapath. Each cycle it takes two operands, a 5-bit operation selector and a 5-bit immediate shift count. It computes one of 24 operations and registers the outcome on the next rising clock edge. The first operand normally comes from the first source register. The second comes either from the second source register or from an extended immediate.

The block has three kinds of output. There is a 32-bit result word. There is a one-bit condition flag that the branch logic uses to decide whether a branch is taken. There is a 64-bit high/low word pair for multiply and divide, which an external high/low register pair can capture. Load-upper-immediate uses the immediate left shift with a count of 16 applied to the second operand. Moves into the high or low register use the pass-through operation.

Top module: `flag_alu`

## Requirements
- R1: While `rst_n` is low, every output is zero. Results appear one clock edge after the inputs are presented.
- R2: Code 0 adds and code 1 subtracts (A minus B). Both wrap modulo 2^32.
- R3: Code 4 is bitwise AND, code 5 is bitwise OR and code 6 is bitwise XOR of A and B.
- R4: Codes 7, 9 and 11 shift B by `shamt_in`: 7 is a logical left shift, 9 a logical right shift and 11 an arithmetic right shift. Code 7 with a count of 16 places B[15:0] in the upper half.
- R5: Codes 8, 10 and 12 shift B left, logically right and arithmetically right respectively. The count is A[4:0], and `shamt_in` has no effect on these codes.
- R6: Code 20 (signed) and code 21 (unsigned) return 1 when A < B and 0 otherwise.
- R7: Code 13 sets the flag when A equals B. Code 18 sets the flag when A differs from B.
- R8: Codes 14, 15, 16 and 17 test signed A against zero for <0, <=0, >0 and >=0 respectively.
- R9: The flag is 0 for every code other than 13 to 18. The result is 0 for codes 13 to 18.
- R10: Code 2 (signed) and code 22 (unsigned) put the full 64-bit product on hi:lo. The result equals lo.
- R11: Code 3 (signed) and code 23 (unsigned) put the quotient on lo and the remainder on hi. The result equals lo. The signed quotient truncates toward zero, and the signed remainder takes the sign of A.
- R12: A divide by zero returns zero on the result, hi and lo.
- R13: Code 19 returns A unchanged as the result.
- R14: hi and lo are zero for every code except 2, 3, 22 and 23. Codes 24 to 31 produce an all-zero output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_a | input | 32 | First operand (source register) |
| op_b | input | 32 | Second operand (register or immediate) |
| op_code | input | 5 | Operation selector |
| shamt_in | input | 5 | Immediate shift count |
| alu_result | output | 32 | Registered result word |
| cond_flag | output | 1 | Registered branch condition |
| hi_word | output | 32 | Registered upper product word or remainder |
| lo_word | output | 32 | Registered lower product word or quotient |

## Verification
The only internal state is the output register. A wrong value there shows at the ports on the clock edge right after the operands are applied, and it is replaced one cycle later. A wrong operation select would show up in several ways: a stray condition flag on a non-compare code, nonzero hi/lo words outside multiply and divide, or a set-less-than result wider than one bit. These are checked at the first sampling point. Divide-by-zero and operand pass-through are checked against the operands captured in the previous cycle.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

    typedef enum logic [4:0] {
        OP_ADD     = 5'd0,
        OP_SUB     = 5'd1,
        OP_MULS    = 5'd2,
        OP_DIVS    = 5'd3,
        OP_AND     = 5'd4,
        OP_OR      = 5'd5,
        OP_XOR     = 5'd6,
        OP_SHL_IMM = 5'd7,
        OP_SHL_REG = 5'd8,
        OP_SHR_IMM = 5'd9,
        OP_SHR_REG = 5'd10,
        OP_SAR_IMM = 5'd11,
        OP_SAR_REG = 5'd12,
        OP_CMP_EQ  = 5'd13,
        OP_CMP_LTZ = 5'd14,
        OP_CMP_LEZ = 5'd15,
        OP_CMP_GTZ = 5'd16,
        OP_CMP_GEZ = 5'd17,
        OP_CMP_NE  = 5'd18,
        OP_PASS    = 5'd19,
        OP_SLT_S   = 5'd20,
        OP_SLT_U   = 5'd21,
        OP_MULU    = 5'd22,
        OP_DIVU    = 5'd23
    } alu_op_e;

    typedef enum logic [1:0] {
        SHK_LEFT   = 2'd0,
        SHK_LRIGHT = 2'd1,
        SHK_ARIGHT = 2'd2
    } shift_kind_e;

endpackage

// File: rtl/flag_alu_shifter.sv
module flag_alu_shifter
    import flag_alu_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int SH_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] value_in,
    input  logic [SH_W-1:0]   amount,
    input  shift_kind_e       kind,
    output logic [DATA_W-1:0] value_out
);
    always_comb begin
        unique case (kind)
            SHK_LEFT:   value_out = value_in << amount;
            SHK_LRIGHT: value_out = value_in >> amount;
            SHK_ARIGHT: value_out = $unsigned($signed(value_in) >>> amount);
            default:    value_out = '0;
        endcase
    end
endmodule

// File: rtl/flag_alu_cmp.sv
module flag_alu_cmp
    import flag_alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] b_in,
    input  logic [4:0]        op_in,
    output logic              flag_out
);
    logic a_neg;
    logic a_zero;

    always_comb begin
        a_neg  = a_in[DATA_W-1];
        a_zero = (a_in == '0);
        case (op_in)
            OP_CMP_EQ:  flag_out = (a_in == b_in);
            OP_CMP_NE:  flag_out = (a_in != b_in);
            OP_CMP_LTZ: flag_out = a_neg;
            OP_CMP_LEZ: flag_out = a_neg | a_zero;
            OP_CMP_GTZ: flag_out = ~a_neg & ~a_zero;
            OP_CMP_GEZ: flag_out = ~a_neg;
            default:    flag_out = 1'b0;
        endcase
    end
endmodule

// File: rtl/flag_alu_muldiv.sv
module flag_alu_muldiv #(
    parameter int DATA_W = 32,
    localparam int WIDE_W = 2 * DATA_W
) (
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] b_in,
    input  logic              signed_mode,
    output logic [WIDE_W-1:0] product,
    output logic [DATA_W-1:0] quotient,
    output logic [DATA_W-1:0] remainder
);
    logic [WIDE_W-1:0] a_ext;
    logic [WIDE_W-1:0] b_ext;
    logic              a_neg;
    logic              b_neg;
    logic [DATA_W-1:0] a_mag;
    logic [DATA_W-1:0] b_mag;
    logic [DATA_W-1:0] q_mag;
    logic [DATA_W-1:0] r_mag;

    always_comb begin
        a_ext   = {{DATA_W{signed_mode & a_in[DATA_W-1]}}, a_in};
        b_ext   = {{DATA_W{signed_mode & b_in[DATA_W-1]}}, b_in};
        product = a_ext * b_ext;

        a_neg = signed_mode & a_in[DATA_W-1];
        b_neg = signed_mode & b_in[DATA_W-1];
        a_mag = a_neg ? -a_in : a_in;
        b_mag = b_neg ? -b_in : b_in;

        if (b_in == '0) begin
            q_mag     = '0;
            r_mag     = '0;
            quotient  = '0;
            remainder = '0;
        end else begin
            q_mag     = a_mag / b_mag;
            r_mag     = a_mag % b_mag;
            quotient  = (a_neg ^ b_neg) ? -q_mag : q_mag;
            remainder = a_neg ? -r_mag : r_mag;
        end
    end
endmodule

// File: rtl/flag_alu.sv
module flag_alu
    import flag_alu_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int SH_W  = $clog2(DATA_W),
    localparam int WIDE_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [4:0]        op_code,
    input  logic [SH_W-1:0]   shamt_in,
    output logic [DATA_W-1:0] alu_result,
    output logic              cond_flag,
    output logic [DATA_W-1:0] hi_word,
    output logic [DATA_W-1:0] lo_word
);
    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              flag;
        logic [DATA_W-1:0] hi;
        logic [DATA_W-1:0] lo;
    } alu_out_t;

    alu_out_t out_d;
    alu_out_t out_q;

    // operation-dependent steering of the helper units
    shift_kind_e       sh_kind;
    logic [SH_W-1:0]   sh_amt;
    logic              md_signed;
    logic              op_is_cmp;
    logic              op_is_md;

    logic [DATA_W-1:0] sh_out;
    logic              cmp_flag;
    logic [WIDE_W-1:0] md_prod;
    logic [DATA_W-1:0] md_quot;
    logic [DATA_W-1:0] md_rem;

    always_comb begin
        sh_kind = SHK_LEFT;
        sh_amt  = shamt_in;
        case (op_code)
            OP_SHR_IMM: sh_kind = SHK_LRIGHT;
            OP_SAR_IMM: sh_kind = SHK_ARIGHT;
            OP_SHL_REG: sh_amt  = op_a[SH_W-1:0];
            OP_SHR_REG: begin
                sh_kind = SHK_LRIGHT;
                sh_amt  = op_a[SH_W-1:0];
            end
            OP_SAR_REG: begin
                sh_kind = SHK_ARIGHT;
                sh_amt  = op_a[SH_W-1:0];
            end
            default: ;
        endcase
        md_signed = (op_code == OP_MULS) || (op_code == OP_DIVS);
        op_is_cmp = (op_code >= OP_CMP_EQ) && (op_code <= OP_CMP_NE);
        op_is_md  = (op_code == OP_MULS) || (op_code == OP_DIVS) ||
                    (op_code == OP_MULU) || (op_code == OP_DIVU);
    end

    flag_alu_shifter #(.DATA_W(DATA_W)) shifter_i (
        .value_in  (op_b),
        .amount    (sh_amt),
        .kind      (sh_kind),
        .value_out (sh_out)
    );

    flag_alu_cmp #(.DATA_W(DATA_W)) cmp_i (
        .a_in     (op_a),
        .b_in     (op_b),
        .op_in    (op_code),
        .flag_out (cmp_flag)
    );

    flag_alu_muldiv #(.DATA_W(DATA_W)) muldiv_i (
        .a_in        (op_a),
        .b_in        (op_b),
        .signed_mode (md_signed),
        .product     (md_prod),
        .quotient    (md_quot),
        .remainder   (md_rem)
    );

    always_comb begin
        out_d      = '0;
        out_d.flag = cmp_flag;
        case (op_code)
            OP_ADD:     out_d.res = op_a + op_b;
            OP_SUB:     out_d.res = op_a - op_b;
            OP_AND:     out_d.res = op_a & op_b;
            OP_OR:      out_d.res = op_a | op_b;
            OP_XOR:     out_d.res = op_a ^ op_b;
            OP_SHL_IMM, OP_SHL_REG, OP_SHR_IMM, OP_SHR_REG,
            OP_SAR_IMM, OP_SAR_REG:
                        out_d.res = sh_out;
            OP_PASS:    out_d.res = op_a;
            OP_SLT_S:   out_d.res = {{(DATA_W-1){1'b0}}, ($signed(op_a) < $signed(op_b))};
            OP_SLT_U:   out_d.res = {{(DATA_W-1){1'b0}}, (op_a < op_b)};
            OP_MULS, OP_MULU: begin
                out_d.hi  = md_prod[WIDE_W-1:DATA_W];
                out_d.lo  = md_prod[DATA_W-1:0];
                out_d.res = md_prod[DATA_W-1:0];
            end
            OP_DIVS, OP_DIVU: begin
                out_d.hi  = md_rem;
                out_d.lo  = md_quot;
                out_d.res = md_quot;
            end
            default:    out_d.res = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign alu_result = out_q.res;
    assign cond_flag  = out_q.flag;
    assign hi_word    = out_q.hi;
    assign lo_word    = out_q.lo;

    // flag may only rise after a comparison code
    p_flag_only_cmp_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(op_is_cmp)) |-> !cond_flag);

    // hi/lo stay clear outside multiply and divide
    p_hilo_idle_r14: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(op_is_md)) |-> (hi_word == '0 && lo_word == '0));

    // set-less-than yields a single-bit value
    p_slt_bool_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(op_code) == OP_SLT_S || $past(op_code) == OP_SLT_U))
        |-> (alu_result[DATA_W-1:1] == '0));

    // divide by zero clears everything
    p_div_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(op_code) == OP_DIVS || $past(op_code) == OP_DIVU)
         && $past(op_b) == '0)
        |-> (alu_result == '0 && hi_word == '0 && lo_word == '0));

    // equality flag follows the operands of the previous cycle
    p_eq_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_code) == OP_CMP_EQ)
        |-> (cond_flag == ($past(op_a) == $past(op_b))));

    // pass-through returns the first operand
    p_pass_a_r13: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_code) == OP_PASS) |-> (alu_result == $past(op_a)));

endmodule

// File: tb/flag_alu_tb_top.sv
module flag_alu_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic [4:0]  op_code = '0;
    logic [4:0]  shamt_in = '0;
    logic [31:0] alu_result;
    logic        cond_flag;
    logic [31:0] hi_word;
    logic [31:0] lo_word;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    flag_alu dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_a       (op_a),
        .op_b       (op_b),
        .op_code    (op_code),
        .shamt_in   (shamt_in),
        .alu_result (alu_result),
        .cond_flag  (cond_flag),
        .hi_word    (hi_word),
        .lo_word    (lo_word)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // drive at a falling edge, register on the rising edge, sample at the next falling edge
    task automatic apply(input logic [4:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic [4:0] sh);
        @(negedge clk);
        op_code  = op;
        op_a     = a;
        op_b     = b;
        shamt_in = sh;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset;
        op_code = 5'd0; op_a = 32'hFFFF_FFFF; op_b = 32'd9; shamt_in = 5'd3;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 result in reset", {32'd0, alu_result}, 64'd0);
        chk("R1 flag/hi/lo in reset", {31'd0, cond_flag, hi_word}, 64'd0);
        chk("R1 lo in reset", {32'd0, lo_word}, 64'd0);
        rst_n = 1'b1;
    endtask

    task automatic t_arith;
        apply(5'd0, 32'hFFFF_FFFF, 32'd2, 5'd0);
        chk("R2 add wrap", {32'd0, alu_result}, 64'd1);
        chk("R9 add no flag", {63'd0, cond_flag}, 64'd0);
        apply(5'd1, 32'd3, 32'd5, 5'd0);
        chk("R2 sub", {32'd0, alu_result}, 64'h0000_0000_FFFF_FFFE);
    endtask

    task automatic t_logic;
        apply(5'd4, 32'hF0F0_00FF, 32'h0FF0_0F0F, 5'd0);
        chk("R3 and", {32'd0, alu_result}, 64'h00F0_000F);
        apply(5'd5, 32'hF0F0_00FF, 32'h0FF0_0F0F, 5'd0);
        chk("R3 or", {32'd0, alu_result}, 64'hFFF0_0FFF);
        apply(5'd6, 32'hF0F0_00FF, 32'h0FF0_0F0F, 5'd0);
        chk("R3 xor", {32'd0, alu_result}, 64'hFF00_0FF0);
    endtask

    task automatic t_imm_shift;
        apply(5'd7, 32'hAAAA_AAAA, 32'h0000_1234, 5'd16);
        chk("R4 upper-immediate shift", {32'd0, alu_result}, 64'h1234_0000);
        apply(5'd9, 32'd0, 32'h8000_0000, 5'd4);
        chk("R4 logical right", {32'd0, alu_result}, 64'h0800_0000);
        apply(5'd11, 32'd0, 32'h8000_0000, 5'd4);
        chk("R4 arith right", {32'd0, alu_result}, 64'hF800_0000);
    endtask

    task automatic t_reg_shift;
        apply(5'd8, 32'h0000_0023, 32'd1, 5'd7);
        chk("R5 var left uses A[4:0]", {32'd0, alu_result}, 64'd8);
        apply(5'd10, 32'hFFFF_FFE1, 32'h8000_0000, 5'd9);
        chk("R5 var logical right", {32'd0, alu_result}, 64'h4000_0000);
        apply(5'd12, 32'hFFFF_FFE1, 32'h8000_0000, 5'd9);
        chk("R5 var arith right", {32'd0, alu_result}, 64'hC000_0000);
    endtask

    task automatic t_slt;
        apply(5'd20, 32'hFFFF_FFFF, 32'd1, 5'd0);
        chk("R6 signed less", {32'd0, alu_result}, 64'd1);
        apply(5'd21, 32'hFFFF_FFFF, 32'd1, 5'd0);
        chk("R6 unsigned not less", {32'd0, alu_result}, 64'd0);
        apply(5'd21, 32'd1, 32'hFFFF_FFFF, 5'd0);
        chk("R6 unsigned less", {32'd0, alu_result}, 64'd1);
    endtask

    task automatic t_eq;
        apply(5'd13, 32'd5, 32'd5, 5'd0);
        chk("R7 eq flag", {63'd0, cond_flag}, 64'd1);
        chk("R9 compare result zero", {32'd0, alu_result}, 64'd0);
        apply(5'd13, 32'd5, 32'd6, 5'd0);
        chk("R7 eq clear", {63'd0, cond_flag}, 64'd0);
        apply(5'd18, 32'd5, 32'd5, 5'd0);
        chk("R7 ne clear", {63'd0, cond_flag}, 64'd0);
        apply(5'd18, 32'd5, 32'd6, 5'd0);
        chk("R7 ne set", {63'd0, cond_flag}, 64'd1);
    endtask

    task automatic t_zero_tests;
        apply(5'd14, 32'h8000_0000, 32'd0, 5'd0);
        chk("R8 ltz negative", {63'd0, cond_flag}, 64'd1);
        apply(5'd14, 32'd0, 32'd0, 5'd0);
        chk("R8 ltz zero", {63'd0, cond_flag}, 64'd0);
        apply(5'd15, 32'd0, 32'd0, 5'd0);
        chk("R8 lez zero", {63'd0, cond_flag}, 64'd1);
        apply(5'd15, 32'd1, 32'd0, 5'd0);
        chk("R8 lez positive", {63'd0, cond_flag}, 64'd0);
        apply(5'd16, 32'd0, 32'd0, 5'd0);
        chk("R8 gtz zero", {63'd0, cond_flag}, 64'd0);
        apply(5'd16, 32'd1, 32'd0, 5'd0);
        chk("R8 gtz positive", {63'd0, cond_flag}, 64'd1);
        apply(5'd17, 32'd0, 32'd0, 5'd0);
        chk("R8 gez zero", {63'd0, cond_flag}, 64'd1);
        apply(5'd17, 32'hFFFF_FFFF, 32'd0, 5'd0);
        chk("R8 gez negative", {63'd0, cond_flag}, 64'd0);
    endtask

    task automatic t_mul;
        apply(5'd2, 32'hFFFF_FFFD, 32'd5, 5'd0);
        chk("R10 signed product", {hi_word, lo_word}, 64'hFFFF_FFFF_FFFF_FFF1);
        chk("R10 result is lo", {32'd0, alu_result}, 64'hFFFF_FFF1);
        apply(5'd22, 32'hFFFF_FFFF, 32'd2, 5'd0);
        chk("R10 unsigned product", {hi_word, lo_word}, 64'h0000_0001_FFFF_FFFE);
    endtask

    task automatic t_div;
        apply(5'd3, 32'hFFFF_FFF9, 32'd2, 5'd0);
        chk("R11 signed div", {hi_word, lo_word}, 64'hFFFF_FFFF_FFFF_FFFD);
        apply(5'd23, 32'd7, 32'd2, 5'd0);
        chk("R11 unsigned div", {hi_word, lo_word}, 64'h0000_0001_0000_0003);
        apply(5'd23, 32'hFFFF_FFF9, 32'd2, 5'd0);
        chk("R11 unsigned big", {hi_word, lo_word}, 64'h0000_0001_7FFF_FFFC);
        chk("R11 result is lo", {32'd0, alu_result}, 64'h7FFF_FFFC);
    endtask

    task automatic t_div_zero;
        apply(5'd3, 32'd77, 32'd0, 5'd0);
        chk("R12 signed div by zero", {hi_word, lo_word}, 64'd0);
        chk("R12 signed div by zero result", {32'd0, alu_result}, 64'd0);
        apply(5'd23, 32'hFFFF_FFFF, 32'd0, 5'd0);
        chk("R12 unsigned div by zero", {hi_word, lo_word}, 64'd0);
    endtask

    task automatic t_pass_unused;
        apply(5'd19, 32'hDEAD_BEEF, 32'h1234_5678, 5'd3);
        chk("R13 pass A", {32'd0, alu_result}, 64'hDEAD_BEEF);
        chk("R14 pass no hi/lo", {hi_word, lo_word}, 64'd0);
        apply(5'd24, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd31);
        chk("R14 code 24 zero", {31'd0, cond_flag, alu_result}, 64'd0);
        chk("R14 code 24 hi/lo", {hi_word, lo_word}, 64'd0);
        apply(5'd31, 32'h0000_0001, 32'h0000_0001, 5'd1);
        chk("R14 code 31 zero", {31'd0, cond_flag, alu_result}, 64'd0);
    endtask

    initial begin
        t_reset();
        t_arith();
        t_logic();
        t_imm_shift();
        t_reg_shift();
        t_slt();
        t_eq();
        t_zero_tests();
        t_mul();
        t_div();
        t_div_zero();
        t_pass_unused();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #400000;
        total++;
        bad++;
        $display("FAIL watchdog expired act=running exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule